// File: doc/BRIEF.md
# Condition Code Flag Register

This block stores the five status bits of a small 8-bit processor and works out their next values after each operation. The datapath gives it both ALU operands, the ALU result, a side bit (the bit shifted out by a shift or rotate, or the bit examined by a bit-test-and-branch) and a 3-bit operation class. From these the block finds the carry between the two nibbles, the carry or borrow out of the top bit, the sign and the zero state of the result.

The interrupt mask bit is kept apart from the result flags. Only explicit set and clear commands change it. When an interrupt return restores the register, a byte pulled from the stack is loaded into all five bits at once. A byte-wide view is always available for pushing onto the stack.

All changes become visible on the clock edge after the inputs are sampled. The asynchronous active-low reset is released through an internal two-stage synchronizer, so the register starts taking inputs on the third rising edge after `rst_n` goes high.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is held, and for the two rising edges after `rst_n` is released, the register reads mask=1 and H=N=Z=C=0, so `ccr_byte` = 0xE8.
- R2: Half carry (H) is written only by class ADD (1) and ADC (2). It takes the carry out of bit 3 into bit 4, worked out from the operands and the result. Every other class leaves H unchanged.
- R3: For classes ADD, ADC, SUB (3), LOGIC (4) and SHIFT (5), N takes result bit 7 and Z is one exactly when the result is 0x00.
- R4: C takes the carry out of bit 7 for ADD and ADC. For SUB it takes the borrow into bit 7, so C is one when the unsigned minuend is below the subtrahend plus the incoming borrow. LOGIC leaves C unchanged.
- R5: SHIFT (5) and BITTEST (6) load C from `aux_bit`. BITTEST leaves N and Z unchanged.
- R6: `mask_set` sets the mask bit and `mask_clr` clears it. When both are high, set wins. No operation class changes the mask bit.
- R7: `pull_en` loads H, I, N, Z, C from `pull_byte` bits 4, 3, 2, 1, 0 and ignores bits 7 to 5. It overrides any operation update and any mask command in the same cycle.
- R8: `ccr_byte` always reads bits 7:5 as 1, followed by H, I, N, Z, C from bit 4 down to bit 0.
- R9: With `upd_en` low, or with class NONE (0) or the spare code 7, an operation changes no flag.
- R10: An accepted update appears on the outputs right after the rising edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Apply the operation class this cycle |
| op_cls | input | 3 | Operation class: 0 NONE, 1 ADD, 2 ADC, 3 SUB, 4 LOGIC, 5 SHIFT, 6 BITTEST, 7 spare |
| opnd_a | input | 8 | First ALU operand (minuend for SUB) |
| opnd_m | input | 8 | Second ALU operand (subtrahend for SUB) |
| alu_res | input | 8 | ALU result |
| aux_bit | input | 1 | Bit shifted out, or bit tested |
| mask_set | input | 1 | Set the interrupt mask bit |
| mask_clr | input | 1 | Clear the interrupt mask bit |
| pull_en | input | 1 | Load the register from `pull_byte` |
| pull_byte | input | 8 | Byte pulled from the stack |
| flag_h | output | 1 | Half carry |
| flag_i | output | 1 | Interrupt mask |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry or borrow |
| ccr_byte | output | 8 | Byte view for stacking |

## Verification
Every flag is a register output, so a wrong next-state choice shows on `ccr_byte` one edge after the faulty update. A flag that should have held is wrong from that point until another class writes it, because the block never recomputes a held bit. The bench therefore checks after every operation. It uses sequences in which earlier values must survive, so that H keeps its value through SUB, N and Z keep theirs through BITTEST, and I is not touched by ALU classes. A wrong priority between pull, mask and update shows only when these arrive in the same cycle, so the bench drives them together.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [2:0] {
    OPC_NONE    = 3'd0,
    OPC_ADD     = 3'd1,
    OPC_ADC     = 3'd2,
    OPC_SUB     = 3'd3,
    OPC_LOGIC   = 3'd4,
    OPC_SHIFT   = 3'd5,
    OPC_BITTEST = 3'd6,
    OPC_SPARE   = 3'd7
  } opc_e;

  typedef struct packed {
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam int unsigned VIEW_W    = 8;
  localparam int unsigned FLAG_W    = 5;
  localparam logic [2:0]  VIEW_FILL = 3'b111;

  typedef struct packed {
    logic we_h;
    logic we_nz;
    logic we_c;
  } flag_we_t;

endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  opc_e           op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  m,
  input  logic [DW-1:0]  r,
  input  logic           aux,
  output flags_t         res,
  output flag_we_t       we
);

  localparam int unsigned MSB = DW - 1;
  localparam int unsigned HB  = DW / 2 - 1;

  logic [DW-1:0] add_co;
  logic [DW-1:0] sub_bo;
  logic          res_zero;

  // Per-bit carry and borrow out, rebuilt from operands and result.
  for (genvar b = 0; b < DW; b++) begin : g_chain
    assign add_co[b] = (a[b] & m[b]) | (m[b] & ~r[b]) | (~r[b] & a[b]);
    assign sub_bo[b] = (~a[b] & m[b]) | (m[b] & r[b]) | (r[b] & ~a[b]);
  end

  assign res_zero = ~|r;

  always_comb begin
    res     = '0;
    res.h   = add_co[HB];
    res.n   = r[MSB];
    res.z   = res_zero;
    res.c   = 1'b0;
    we      = '0;
    unique case (op)
      OPC_ADD, OPC_ADC: begin
        we    = '{we_h: 1'b1, we_nz: 1'b1, we_c: 1'b1};
        res.c = add_co[MSB];
      end
      OPC_SUB: begin
        we    = '{we_h: 1'b0, we_nz: 1'b1, we_c: 1'b1};
        res.c = sub_bo[MSB];
      end
      OPC_LOGIC: begin
        we    = '{we_h: 1'b0, we_nz: 1'b1, we_c: 1'b0};
      end
      OPC_SHIFT: begin
        we    = '{we_h: 1'b0, we_nz: 1'b1, we_c: 1'b1};
        res.c = aux;
      end
      OPC_BITTEST: begin
        we    = '{we_h: 1'b0, we_nz: 1'b0, we_c: 1'b1};
        res.c = aux;
      end
      default: begin
        we    = '0;
      end
    endcase
  end

endmodule

// File: rtl/ccr_flag_store.sv
module ccr_flag_store
  import ccr_pkg::*;
(
  input  logic                clk,
  input  logic                srst_n,
  input  logic                upd_en,
  input  flag_we_t            calc_we,
  input  flags_t              calc_res,
  input  logic                mask_set,
  input  logic                mask_clr,
  input  logic                pull_en,
  input  logic [VIEW_W-1:0]   pull_byte,
  output flags_t              cur
);

  flags_t flags_q;
  flags_t flags_d;
  logic   en_h;
  logic   en_i;
  logic   en_nz;
  logic   en_c;
  flags_t pulled;

  assign pulled = flags_t'(pull_byte[FLAG_W-1:0]);

  // Clock enables, one per field group.
  assign en_h  = pull_en | (upd_en & calc_we.we_h);
  assign en_nz = pull_en | (upd_en & calc_we.we_nz);
  assign en_c  = pull_en | (upd_en & calc_we.we_c);
  assign en_i  = pull_en | mask_set | mask_clr;

  always_comb begin
    flags_d = flags_q;
    if (pull_en) begin
      flags_d = pulled;
    end else begin
      flags_d.h = calc_res.h;
      flags_d.n = calc_res.n;
      flags_d.z = calc_res.z;
      flags_d.c = calc_res.c;
      flags_d.i = mask_set;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flags_q <= '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};
    end else begin
      if (en_h) begin
        flags_q.h <= flags_d.h;
      end
      if (en_i) begin
        flags_q.i <= flags_d.i;
      end
      if (en_nz) begin
        flags_q.n <= flags_d.n;
        flags_q.z <= flags_d.z;
      end
      if (en_c) begin
        flags_q.c <= flags_d.c;
      end
    end
  end

  assign cur = flags_q;

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_en,
  input  logic [2:0]     op_cls,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_m,
  input  logic [DW-1:0]  alu_res,
  input  logic           aux_bit,
  input  logic           mask_set,
  input  logic           mask_clr,
  input  logic           pull_en,
  input  logic [7:0]     pull_byte,
  output logic           flag_h,
  output logic           flag_i,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_c,
  output logic [7:0]     ccr_byte
);

  logic     srst_n;
  flags_t   calc_res;
  flag_we_t calc_we;
  flags_t   cur;

  ccr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ccr_flag_calc #(.DW(DW)) u_calc (
    .op  (opc_e'(op_cls)),
    .a   (opnd_a),
    .m   (opnd_m),
    .r   (alu_res),
    .aux (aux_bit),
    .res (calc_res),
    .we  (calc_we)
  );

  ccr_flag_store u_store (
    .clk       (clk),
    .srst_n    (srst_n),
    .upd_en    (upd_en),
    .calc_we   (calc_we),
    .calc_res  (calc_res),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .pull_en   (pull_en),
    .pull_byte (pull_byte),
    .cur       (cur)
  );

  assign flag_h   = cur.h;
  assign flag_i   = cur.i;
  assign flag_n   = cur.n;
  assign flag_z   = cur.z;
  assign flag_c   = cur.c;
  assign ccr_byte = {VIEW_FILL, cur};

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          srst_n,
  input logic          upd_en,
  input logic [2:0]    op_cls,
  input logic [DW-1:0] alu_res,
  input logic          mask_set,
  input logic          mask_clr,
  input logic          pull_en,
  input logic [7:0]    pull_byte,
  input logic [7:0]    ccr_byte
);

  AST_H_ONLY_ADD: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && !(upd_en && (op_cls == 3'd1 || op_cls == 3'd2))) |=> $stable(ccr_byte[4])); // R2

  AST_LOGIC_NZ: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && upd_en && op_cls == 3'd4) |=>
      (ccr_byte[1] == ($past(alu_res) == '0)) && (ccr_byte[2] == $past(alu_res[DW-1]))); // R3

  AST_MASK_SET_WINS: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && mask_set) |=> ccr_byte[3]); // R6

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && mask_clr && !mask_set) |=> !ccr_byte[3]); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && !mask_set && !mask_clr) |=> $stable(ccr_byte[3])); // R6

  AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    pull_en |=> ccr_byte[4:0] == $past(pull_byte[4:0])); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!pull_en && (!upd_en || op_cls == 3'd0 || op_cls == 3'd7)) |=>
      ($stable(ccr_byte[4]) && $stable(ccr_byte[2:0]))); // R9

endmodule

bind ccr_flag_unit ccr_flag_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .upd_en    (upd_en),
  .op_cls    (op_cls),
  .alu_res   (alu_res),
  .mask_set  (mask_set),
  .mask_clr  (mask_clr),
  .pull_en   (pull_en),
  .pull_byte (pull_byte),
  .ccr_byte  (ccr_byte)
);

// File: tb/sim_ccr_flag_unit.sv
`timescale 1ns/1ps
module sim_ccr_flag_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       upd_en;
  logic [2:0] op_cls;
  logic [7:0] opnd_a, opnd_m, alu_res, pull_byte;
  logic       aux_bit, mask_set, mask_clr, pull_en;
  logic       flag_h, flag_i, flag_n, flag_z, flag_c;
  logic [7:0] ccr_byte;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;

  logic eh, ei, en, ez, ec;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ccr_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
    .opnd_a(opnd_a), .opnd_m(opnd_m), .alu_res(alu_res), .aux_bit(aux_bit),
    .mask_set(mask_set), .mask_clr(mask_clr), .pull_en(pull_en),
    .pull_byte(pull_byte), .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .ccr_byte(ccr_byte)
  );

  function automatic logic [7:0] exp_byte();
    return {3'b111, eh, ei, en, ez, ec};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic idle();
    upd_en = 0; op_cls = 3'd0; opnd_a = 0; opnd_m = 0; alu_res = 0;
    aux_bit = 0; mask_set = 0; mask_clr = 0; pull_en = 0; pull_byte = 0;
  endtask

  // Drive one cycle, then release to idle; outputs change after that edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_add(input string tag, input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic cin);
    logic [8:0] sum;
    sum = {1'b0, a} + {1'b0, m} + {8'd0, cin};
    upd_en = 1; op_cls = op; opnd_a = a; opnd_m = m; alu_res = sum[7:0];
    eh = ({1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'd0, cin}) > 5'd15;
    ec = sum[8]; en = sum[7]; ez = (sum[7:0] == 8'h00);
    step();
    chk(tag, ccr_byte, exp_byte());
  endtask

  task automatic do_sub(input string tag, input logic [7:0] a, input logic [7:0] m,
                        input logic bin);
    logic [7:0] d;
    d = a - m - {7'd0, bin};
    upd_en = 1; op_cls = 3'd3; opnd_a = a; opnd_m = m; alu_res = d;
    ec = ({1'b0, a} < ({1'b0, m} + {8'd0, bin}));
    en = d[7]; ez = (d == 8'h00);
    step();
    chk(tag, ccr_byte, exp_byte());
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    eh = 0; ei = 1; en = 0; ez = 0; ec = 0;
    chk("R1 reset value", ccr_byte, 8'hE8);
    rst_n = 1;
    // Commands during the synchronizer window must not land.
    mask_clr = 1; pull_en = 1; pull_byte = 8'h17;
    @(negedge clk);
    chk("R1 held during sync edge 1", ccr_byte, 8'hE8);
    @(negedge clk);
    chk("R1 held during sync edge 2", ccr_byte, 8'hE8);
    idle();
    @(negedge clk);
    chk("R8 byte layout after reset", ccr_byte, exp_byte());
  endtask

  task automatic t_add();
    do_add("R2 R4 add nibble carry",    3'd1, 8'h08, 8'h08, 1'b0);
    do_add("R2 R3 R4 add wrap to zero", 3'd1, 8'hFF, 8'h01, 1'b0);
    do_add("R3 add negative no carry",  3'd1, 8'h70, 8'h10, 1'b0);
    do_add("R2 adc carry-in half",      3'd2, 8'h0F, 8'h00, 1'b1);
    do_add("R4 adc carry-in full",      3'd2, 8'hF0, 8'h0F, 1'b1);
  endtask

  task automatic t_sub();
    // First set H so SUB can be seen leaving it alone.
    do_add("R2 add sets H", 3'd1, 8'h09, 8'h09, 1'b0);
    do_sub("R2 R4 sub borrow keeps H", 8'h10, 8'h20, 1'b0);
    do_sub("R3 R4 sub equal zero",     8'h05, 8'h05, 1'b0);
    do_sub("R4 sbc borrow-in",         8'h05, 8'h05, 1'b1);
  endtask

  task automatic t_logic();
    logic [7:0] vals [3] = '{8'h00, 8'h80, 8'h41};
    do_add("R4 add sets C", 3'd1, 8'hF8, 8'h08, 1'b0);
    foreach (vals[k]) begin
      upd_en = 1; op_cls = 3'd4; alu_res = vals[k]; opnd_a = 8'h5A; opnd_m = 8'hA5;
      en = vals[k][7]; ez = (vals[k] == 8'h00);
      step();
      chk("R3 R4 logic nz only", ccr_byte, exp_byte());
    end
  endtask

  task automatic t_shift_bit();
    upd_en = 1; op_cls = 3'd5; alu_res = 8'h00; aux_bit = 1;
    en = 0; ez = 1; ec = 1;
    step();
    chk("R5 shift C from aux", ccr_byte, exp_byte());
    upd_en = 1; op_cls = 3'd5; alu_res = 8'hC0; aux_bit = 0;
    en = 1; ez = 0; ec = 0;
    step();
    chk("R5 shift negative", ccr_byte, exp_byte());
    upd_en = 1; op_cls = 3'd6; alu_res = 8'h00; aux_bit = 1;
    ec = 1;
    step();
    chk("R5 bittest keeps NZ", ccr_byte, exp_byte());
  endtask

  task automatic t_mask();
    mask_clr = 1; ei = 0;
    step();
    chk("R6 mask clear", ccr_byte, exp_byte());
    do_add("R6 add keeps mask", 3'd1, 8'h01, 8'h01, 1'b0);
    mask_set = 1; mask_clr = 1; ei = 1;
    step();
    chk("R6 set wins", ccr_byte, exp_byte());
    mask_clr = 1; ei = 0;
    step();
    mask_set = 1; ei = 1;
    step();
    chk("R6 mask set", ccr_byte, exp_byte());
  endtask

  task automatic t_pull();
    pull_en = 1; pull_byte = 8'h1F;
    {eh, ei, en, ez, ec} = 5'b11111;
    step();
    chk("R7 pull all ones", ccr_byte, 8'hFF);
    pull_en = 1; pull_byte = 8'hE0;
    {eh, ei, en, ez, ec} = 5'b00000;
    step();
    chk("R7 R8 pull ignores top bits", ccr_byte, 8'hE0);
    pull_en = 1; pull_byte = 8'h0A; mask_set = 1;
    upd_en = 1; op_cls = 3'd1; opnd_a = 8'hFF; opnd_m = 8'hFF; alu_res = 8'hFE;
    {eh, ei, en, ez, ec} = 5'b01010;
    step();
    chk("R7 pull beats update and mask", ccr_byte, exp_byte());
  endtask

  task automatic t_hold();
    upd_en = 0; op_cls = 3'd1; opnd_a = 8'hFF; opnd_m = 8'hFF; alu_res = 8'hFE;
    step();
    chk("R9 upd_en low holds", ccr_byte, exp_byte());
    upd_en = 1; op_cls = 3'd0; alu_res = 8'h80; aux_bit = 1;
    step();
    chk("R9 class none holds", ccr_byte, exp_byte());
    upd_en = 1; op_cls = 3'd7; alu_res = 8'h00; aux_bit = 1;
    step();
    chk("R9 spare class holds", ccr_byte, exp_byte());
  endtask

  task automatic t_timing();
    upd_en = 1; op_cls = 3'd5; alu_res = 8'h80; aux_bit = 1;
    @(posedge clk);
    #1;
    chk("R10 visible after edge", ccr_byte, {3'b111, eh, ei, 1'b1, 1'b0, 1'b1});
    en = 1; ez = 0; ec = 1;
    @(negedge clk);
    idle();
    upd_en = 1; op_cls = 3'd4; alu_res = 8'h00;
    #1;
    chk("R10 not before edge", ccr_byte, exp_byte());
    ez = 1; en = 0;
    step();
    chk("R10 applied next edge", ccr_byte, exp_byte());
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift_bit();
    t_mask();
    t_pull();
    t_hold();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc >= 5000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired got=%0d exp=<5000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule